// File: doc/BRIEF.md
# Bus-Writable Pending Interrupt Register

This block keeps the pending hardware interrupt state of a processor core. Seven stored bits can be changed by an external agent through a write on the shared, multiplexed address/data bus. The address cycle selects the register. The data cycle that follows carries two fields: a per-bit enable mask and the new bit values. In one transaction any subset of the bits can be set, cleared or left alone.

The block merges the stored bits with the interrupt pins, which are active low. Six maskable pin lines are merged with stored bits 5..0, and the non-maskable pin is merged with stored bit 6. The merged result is registered and goes to the core as pending flags. The block also holds two software interrupt bits that the core loads directly. Priority selection, masking by the core's status register and exception entry are left to the core.

Top module: `irq_pend_reg`

## Requirements
- R1: A synchronous active-high reset clears all stored bits, the software bits and every pending output.
- R2: An address cycle selects the register only when it is a write and address bits [6:4] are 000. With any other value in those bits, the data cycle that follows changes nothing.
- R3: In the data cycle after a selecting address cycle, each stored bit i (0..6) whose enable bus_data[16+i] is 1 takes the value bus_data[i]. The new value appears on the pending outputs two clock edges after the data cycle.
- R4: A stored bit whose enable in the data cycle is 0 keeps its previous value.
- R5: hw_pend[i] equals stored bit i ORed with the inverted pin int_n[i], registered once, for i = 0..5.
- R6: nmi_pend equals stored bit 6 ORed with the inverted pin nmi_n, registered once.
- R7: An address cycle that is a read does not select the register. A data cycle with no selecting address cycle before it is ignored. Only the first data cycle after a selecting address cycle performs an update.
- R8: When sw_we is 1, sw_pend takes sw_val at the next edge. Bus writes never change sw_pend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_is_addr | input | 1 | 1 = address cycle, 0 = data cycle |
| bus_wr | input | 1 | In an address cycle, 1 = write request |
| bus_data | input | 32 | Multiplexed address/data word |
| int_n | input | 6 | Maskable interrupt pins, active low |
| nmi_n | input | 1 | Non-maskable interrupt pin, active low |
| sw_we | input | 1 | Load strobe for the software bits |
| sw_val | input | 2 | New software interrupt bit values |
| hw_pend | output | 6 | Pending maskable interrupts |
| nmi_pend | output | 1 | Pending non-maskable interrupt |
| sw_pend | output | 2 | Pending software interrupts |

## Verification
The first write enables all seven bits with alternating values. It shows whether each enable reaches its own bit and whether the non-maskable bit is routed apart from the maskable ones. A partial mask that clears only the low nibble separates a masked update from a full overwrite. Writes aimed at another address, read commands, orphan data cycles and a second data cycle after one address cycle each leave the stored pattern unchanged, which shows the decode and arming are correct. Driving one pin low while its stored bit is 0 shows the pin merge separately from the bus path.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  // Classification of the bus cycle seen in a clock
  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_ADDR_WR,
    CYC_ADDR_OTHER,
    CYC_DATA
  } cyc_kind_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_pend_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SEL_LSB   = 4,
  parameter int SEL_W     = 3,
  parameter int SEL_MATCH = 0,
  parameter int EN_LSB    = 16,
  parameter int VAL_LSB   = 0,
  parameter int REG_W     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_is_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              upd,
  output logic [REG_W-1:0]  upd_en,
  output logic [REG_W-1:0]  upd_val
);
  localparam logic [SEL_W-1:0] SEL_CODE = SEL_W'(SEL_MATCH);

  cyc_kind_e kind;
  logic      armed_q;
  logic      sel_hit;
  logic      unused_bits;

  assign sel_hit     = (bus_data[SEL_LSB +: SEL_W] == SEL_CODE);
  assign unused_bits = ^bus_data;

  always_comb begin
    if (!bus_valid)       kind = CYC_IDLE;
    else if (!bus_is_addr) kind = CYC_DATA;
    else if (bus_wr)      kind = CYC_ADDR_WR;
    else                  kind = CYC_ADDR_OTHER;
  end

  // Armed from a selecting write address until the next valid cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else begin
      case (kind)
        CYC_ADDR_WR:    armed_q <= sel_hit;
        CYC_ADDR_OTHER: armed_q <= 1'b0;
        CYC_DATA:       armed_q <= 1'b0;
        default:        armed_q <= armed_q;
      endcase
    end
  end

  assign upd     = (kind == CYC_DATA) && armed_q;
  assign upd_en  = bus_data[EN_LSB +: REG_W];
  assign upd_val = bus_data[VAL_LSB +: REG_W];

  AST_ONE_UPD_PER_ADDR: assert property (@(posedge clk) disable iff (rst)
    upd |=> !upd); // R7
endmodule

// File: rtl/irq_store_bank.sv
module irq_store_bank #(
  parameter int REG_W = 7,
  parameter int SW_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [REG_W-1:0] upd_en,
  input  logic [REG_W-1:0] upd_val,
  input  logic             sw_we,
  input  logic [SW_W-1:0]  sw_val,
  output logic [REG_W-1:0] stored_q,
  output logic [SW_W-1:0]  sw_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stored_q <= '0;
    end else if (upd) begin
      stored_q <= (stored_q & ~upd_en) | (upd_val & upd_en);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        sw_q <= '0;
    else if (sw_we) sw_q <= sw_val;
  end

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (stored_q == '0 && sw_q == '0)); // R1
  AST_ENABLED_LOAD: assert property (@(posedge clk) disable iff (rst)
    upd |=> (((stored_q ^ $past(upd_val)) & $past(upd_en)) == '0)); // R3
  AST_UNENABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((stored_q ^ $past(stored_q)) & ~($past(upd_en) & {REG_W{$past(upd)}})) == '0)); // R4
  AST_SW_LOAD: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> (sw_q == $past(sw_val))); // R8
endmodule

// File: rtl/irq_pin_merge.sv
module irq_pin_merge #(
  parameter int HW_W  = 6,
  parameter int REG_W = HW_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] stored_q,
  input  logic [HW_W-1:0]  int_n,
  input  logic             nmi_n,
  output logic [HW_W-1:0]  hw_pend,
  output logic             nmi_pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hw_pend  <= '0;
      nmi_pend <= 1'b0;
    end else begin
      hw_pend  <= stored_q[HW_W-1:0] | ~int_n;
      nmi_pend <= stored_q[HW_W] | ~nmi_n;
    end
  end

  AST_PIN_REACHES_PEND: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((hw_pend & $past(~int_n)) == $past(~int_n))); // R5
  AST_NMI_REACHES_PEND: assert property (@(posedge clk) disable iff (rst)
    !nmi_n |=> nmi_pend); // R6
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int DATA_W    = 32,
  parameter int HW_W      = 6,
  parameter int SW_W      = 2,
  parameter int SEL_LSB   = 4,
  parameter int SEL_W     = 3,
  parameter int SEL_MATCH = 0,
  parameter int EN_LSB    = 16,
  parameter int VAL_LSB   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_is_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [HW_W-1:0]   int_n,
  input  logic              nmi_n,
  input  logic              sw_we,
  input  logic [SW_W-1:0]   sw_val,
  output logic [HW_W-1:0]   hw_pend,
  output logic              nmi_pend,
  output logic [SW_W-1:0]   sw_pend
);
  localparam int REG_W = HW_W + 1;

  logic             upd;
  logic [REG_W-1:0] upd_en;
  logic [REG_W-1:0] upd_val;
  logic [REG_W-1:0] stored_q;

  irq_bus_decode #(
    .DATA_W(DATA_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .SEL_MATCH(SEL_MATCH),
    .EN_LSB(EN_LSB), .VAL_LSB(VAL_LSB), .REG_W(REG_W)
  ) u_decode (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_is_addr(bus_is_addr),
    .bus_wr(bus_wr), .bus_data(bus_data),
    .upd(upd), .upd_en(upd_en), .upd_val(upd_val)
  );

  irq_store_bank #(.REG_W(REG_W), .SW_W(SW_W)) u_bank (
    .clk(clk), .rst(rst), .upd(upd), .upd_en(upd_en), .upd_val(upd_val),
    .sw_we(sw_we), .sw_val(sw_val), .stored_q(stored_q), .sw_q(sw_pend)
  );

  irq_pin_merge #(.HW_W(HW_W), .REG_W(REG_W)) u_merge (
    .clk(clk), .rst(rst), .stored_q(stored_q), .int_n(int_n), .nmi_n(nmi_n),
    .hw_pend(hw_pend), .nmi_pend(nmi_pend)
  );
endmodule

// File: tb/irq_pend_reg_tb.sv
`timescale 1ns/1ps
module irq_pend_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_is_addr = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_data = '0;
  logic [5:0]  int_n = '1;
  logic        nmi_n = 1'b1;
  logic        sw_we = 1'b0;
  logic [1:0]  sw_val = '0;
  logic [5:0]  hw_pend;
  logic        nmi_pend;
  logic [1:0]  sw_pend;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [6:0] exp_reg = '0;
  logic [1:0] exp_sw  = '0;

  always #4 clk = ~clk;

  irq_pend_reg u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_is_addr(bus_is_addr),
    .bus_wr(bus_wr), .bus_data(bus_data), .int_n(int_n), .nmi_n(nmi_n),
    .sw_we(sw_we), .sw_val(sw_val), .hw_pend(hw_pend), .nmi_pend(nmi_pend),
    .sw_pend(sw_pend)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(logic v, logic a, logic w, logic [31:0] d);
    @(negedge clk);
    bus_valid = v; bus_is_addr = a; bus_wr = w; bus_data = d;
  endtask

  // address, data, idle; ends at the negedge where outputs show the write
  task automatic bus_write(logic [2:0] sel, logic [6:0] en, logic [6:0] val);
    cyc(1, 1, 1, {25'h0, sel, 4'h0});
    cyc(1, 0, 0, {9'h0, en, 9'h0, val});
    cyc(0, 0, 0, 32'h0);
    @(negedge clk);
  endtask

  task automatic check_outs(string req);
    check(req, {26'h0, hw_pend}, {26'h0, exp_reg[5:0] | ~int_n});
    check(req, {31'h0, nmi_pend}, {31'h0, exp_reg[6] | ~nmi_n});
  endtask

  task automatic t_reset_state();
    check("R1 hw", {26'h0, hw_pend}, 32'h0);
    check("R1 nmi", {31'h0, nmi_pend}, 32'h0);
    check("R1 sw", {30'h0, sw_pend}, 32'h0);
  endtask

  task automatic t_full_write();
    bus_write(3'b000, 7'h7F, 7'h55);
    exp_reg = 7'h55;
    check_outs("R3 full mask");
    check("R6 nmi from bit6", {31'h0, nmi_pend}, 32'h1);
  endtask

  task automatic t_partial_write();
    bus_write(3'b000, 7'h0F, 7'h00);
    exp_reg = 7'h50;
    check_outs("R4 partial mask");
    bus_write(3'b000, 7'h22, 7'h7F);
    exp_reg = 7'h72;
    check_outs("R4 sparse mask");
  endtask

  task automatic t_bad_addr();
    bus_write(3'b010, 7'h7F, 7'h00);
    check_outs("R2 addr 010");
    bus_write(3'b111, 7'h7F, 7'h0D);
    check_outs("R2 addr 111");
  endtask

  task automatic t_arming();
    cyc(1, 1, 0, 32'h0);
    cyc(1, 0, 0, {9'h0, 7'h7F, 16'h0});
    cyc(0, 0, 0, 32'h0);
    @(negedge clk);
    check_outs("R7 read address");
    cyc(1, 0, 0, {9'h0, 7'h7F, 16'h0});
    cyc(0, 0, 0, 32'h0);
    @(negedge clk);
    check_outs("R7 orphan data");
    cyc(1, 1, 1, 32'h0);
    cyc(1, 0, 0, {9'h0, 7'h01, 9'h0, 7'h01});
    cyc(1, 0, 0, {9'h0, 7'h7F, 16'h0});
    cyc(0, 0, 0, 32'h0);
    @(negedge clk);
    exp_reg = exp_reg | 7'h01;
    check_outs("R7 second data cycle");
  endtask

  task automatic t_pins();
    @(negedge clk);
    int_n = 6'b110111;
    @(negedge clk);
    check("R5 pin3", {26'h0, hw_pend}, {26'h0, exp_reg[5:0] | 6'b001000});
    int_n = '1;
    @(negedge clk);
    check_outs("R5 pin released");
    bus_write(3'b000, 7'h40, 7'h00);
    exp_reg[6] = 1'b0;
    nmi_n = 1'b0;
    @(negedge clk);
    check("R6 nmi pin", {31'h0, nmi_pend}, 32'h1);
    nmi_n = 1'b1;
    @(negedge clk);
    check("R6 nmi released", {31'h0, nmi_pend}, 32'h0);
  endtask

  task automatic t_software();
    @(negedge clk);
    sw_we = 1'b1; sw_val = 2'b10;
    @(negedge clk);
    sw_we = 1'b0; sw_val = 2'b01;
    exp_sw = 2'b10;
    check("R8 sw load", {30'h0, sw_pend}, {30'h0, exp_sw});
    bus_write(3'b000, 7'h7F, 7'h7F);
    exp_reg = 7'h7F;
    check("R8 sw after bus write", {30'h0, sw_pend}, {30'h0, exp_sw});
    check_outs("R3 all set");
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_reg = '0; exp_sw = '0;
    @(negedge clk);
    check("R1 reset hw", {26'h0, hw_pend}, 32'h0);
    check("R1 reset nmi", {31'h0, nmi_pend}, 32'h0);
    check("R1 reset sw", {30'h0, sw_pend}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_full_write();
    t_partial_write();
    t_bad_addr();
    t_arming();
    t_pins();
    t_software();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule